// File: doc/BRIEF.md
# Serial Download Boot Sequencer

This block stands in for a small boot-ROM loop. Once power-on reset is released it parks in a standby state. It leaves standby only when the wake input goes from low to high. A strap pin, captured while reset is held, selects one of two boot paths. In serial mode the sequencer takes a fixed-size image one byte at a time from a UART receiver (a valid strobe, a data byte and a framing-error flag). It writes each byte to the next address of an on-chip SRAM write port. When the last byte is stored it raises a jump request that carries the SRAM start address. In external mode it touches no SRAM and raises a release that lets instruction fetch proceed from external memory.

The UART bit-level receiver sits outside this block, and so does any later flash programming. The image length, the SRAM start address and the depth of the wake synchronizer are parameters. The default image is 2048 bytes, held in a 12-bit byte counter.

Top module: `serial_boot_seq`

## Requirements
- R1: While reset is held, and in the cycles just after it is released, `sram_we_o`, `jump_o` and `ext_fetch_o` are all 0.
- R2: `strap_n_i` is captured while reset is asserted: 0 selects serial download and 1 selects external boot. Changes to it after reset is released have no effect until the next reset.
- R3: In both modes the sequencer waits in standby until the synchronized `wake_i` rises from 0 to 1. A level that is already high when reset is released does not count as a rise. With `wake_i` raised between clock edges, `ext_fetch_o` is 1 after the third rising clock edge and not after the second.
- R4: In standby, UART bytes produce no SRAM write strobe.
- R5: In external boot, after the wake rise, `ext_fetch_o` is 1 and stays at 1. `sram_we_o` and `jump_o` stay 0 even when UART bytes arrive.
- R6: In serial mode, each byte offered with `rx_valid_i`=1 and `rx_err_i`=0 gives exactly one `sram_we_o` pulse in the same cycle. That pulse carries `sram_wdata_o`=`rx_data_i`, and `sram_addr_o` counts 0,1,2,… in arrival order up to IMAGE_BYTES-1.
- R7: A byte offered with `rx_err_i`=1 produces no write strobe and does not advance the address. The next good byte goes to the address the dropped byte would have used.
- R8: From the cycle after the IMAGE_BYTES-th good byte is written, `jump_o` is 1 and stays 1 until reset, with `jump_addr_o` equal to SRAM_BASE (default 0x1000_0000).
- R9: After the image is complete, further UART bytes produce no write strobe.
- R10: `jump_o` and `ext_fetch_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously and released synchronously inside the block |
| strap_n_i | input | 1 | Boot-select strap, captured during reset (0 = serial download) |
| wake_i | input | 1 | Asynchronous wake request; a rising edge starts the boot |
| rx_valid_i | input | 1 | UART receiver has a byte this cycle |
| rx_data_i | input | 8 | Received byte |
| rx_err_i | input | 1 | Framing error on the byte offered this cycle |
| sram_we_o | output | 1 | SRAM write strobe |
| sram_addr_o | output | 11 | SRAM byte offset being written |
| sram_wdata_o | output | 8 | SRAM write data |
| jump_o | output | 1 | Jump request to SRAM, held once the image is complete |
| jump_addr_o | output | 32 | Jump target (SRAM start address) |
| ext_fetch_o | output | 1 | Release of instruction fetch from external memory |

## Verification
The full image is sent with idle gaps between bytes and framing-error bytes mixed in. This separates a correct counter from one that advances on idle cycles or on dropped bytes, because every later address would then shift. A second pattern offers bytes before the wake rise and again after the image is complete, which exposes strobes that leak outside the load phase. Two more patterns test the gating. One holds wake high through reset release. The other flips the strap right after release in each mode. Together they tell an edge detector from a level detector, and a captured strap from a live one. The wake-to-release latency is checked at the exact cycle, which catches a missing or extra synchronizer stage.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_STANDBY = 3'd1,
    ST_LOAD    = 3'd2,
    ST_DONE    = 3'd3,
    ST_NORMAL  = 3'd4
  } boot_state_e;

endpackage

// File: rtl/bseq_rst_strap.sv
// Reset synchronizer (async assert, sync release) plus the boot strap capture.
module bseq_rst_strap #(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_n_i,
  output logic rst_q_n,
  output logic serial_sel_n
);

  logic [RST_STAGES-1:0] rst_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end

  assign rst_q_n = rst_pipe[RST_STAGES-1];

  // Strap is loaded on every edge while the internal reset is low, frozen after.
  always_ff @(posedge clk) begin
    if (!rst_q_n) serial_sel_n <= strap_n_i;
  end

  // R2: strap copy frozen once reset has been released for a full cycle
  p_strap_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q_n && $past(rst_q_n)) |-> $stable(serial_sel_n));

endmodule

// File: rtl/bseq_wake_det.sv
// Wake synchronizer and rising-edge detector. Stages reset to 1 so a level
// that is already high at reset release is not seen as a rise.
module bseq_wake_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_q_n,
  input  logic wake_i,
  output logic wake_rise
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], wake_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign wake_rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R3: a rise is a single-cycle pulse
  p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    wake_rise |=> !wake_rise);

endmodule

// File: rtl/bseq_byte_cnt.sv
// Image byte counter; its low bits form the SRAM offset.
module bseq_byte_cnt #(
  parameter int IMAGE_BYTES = 2048,
  localparam int CNT_W = $clog2(IMAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             last_byte
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (inc) cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) cnt <= '0;
    else          cnt <= cnt_d;
  end

  assign last_byte = (cnt == CNT_W'(IMAGE_BYTES - 1));

  // R6: each accepted byte advances the offset by exactly one
  p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    inc |=> cnt == $past(cnt) + CNT_W'(1));
  // R7: without an accepted byte the offset holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !inc |=> $stable(cnt));
  // R9: counter never passes the image size
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    cnt <= CNT_W'(IMAGE_BYTES));

endmodule

// File: rtl/bseq_fsm.sv
// Boot sequencing state machine.
module bseq_fsm
  import boot_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_q_n,
  input  logic        serial_sel_n,
  input  logic        wake_rise,
  input  logic        byte_ok,
  input  logic        last_byte,
  output boot_state_e state
);

  boot_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_RESET:   state_d = ST_STANDBY;
      ST_STANDBY: if (wake_rise) state_d = serial_sel_n ? ST_NORMAL : ST_LOAD;
      ST_LOAD:    if (byte_ok && last_byte) state_d = ST_DONE;
      ST_DONE:    state_d = ST_DONE;
      ST_NORMAL:  state_d = ST_NORMAL;
      default:    state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) state <= ST_RESET;
    else          state <= state_d;
  end

  // R3: standby is left only on a wake rise
  p_standby_wait_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state == ST_STANDBY && !wake_rise) |=> state == ST_STANDBY);
  // R2: serial strap value leads to the load phase
  p_serial_path_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state == ST_STANDBY && wake_rise && !serial_sel_n) |=> state == ST_LOAD);
  // R8: the done state is terminal
  p_done_held_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    state == ST_DONE |=> state == ST_DONE);
  // R5: external boot is terminal
  p_normal_held_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    state == ST_NORMAL |=> state == ST_NORMAL);

endmodule

// File: rtl/serial_boot_seq.sv
module serial_boot_seq
  import boot_seq_pkg::*;
#(
  parameter int          IMAGE_BYTES = 2048,
  parameter int          SYNC_STAGES = 2,
  parameter int          RST_STAGES  = 2,
  parameter logic [31:0] SRAM_BASE   = 32'h1000_0000,
  localparam int         ADDR_W      = $clog2(IMAGE_BYTES),
  localparam int         CNT_W       = $clog2(IMAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_n_i,
  input  logic              wake_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_err_i,
  output logic              sram_we_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [7:0]        sram_wdata_o,
  output logic              jump_o,
  output logic [31:0]       jump_addr_o,
  output logic              ext_fetch_o
);

  logic        rst_q_n;
  logic        serial_sel_n;
  logic        wake_rise;
  logic        byte_ok;
  logic        last_byte;
  logic [CNT_W-1:0] cnt;
  boot_state_e state;

  bseq_rst_strap #(.RST_STAGES(RST_STAGES)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_n_i    (strap_n_i),
    .rst_q_n      (rst_q_n),
    .serial_sel_n (serial_sel_n)
  );

  bseq_wake_det #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk       (clk),
    .rst_q_n   (rst_q_n),
    .wake_i    (wake_i),
    .wake_rise (wake_rise)
  );

  assign byte_ok = (state == ST_LOAD) && rx_valid_i && !rx_err_i;

  bseq_byte_cnt #(.IMAGE_BYTES(IMAGE_BYTES)) u_cnt (
    .clk       (clk),
    .rst_q_n   (rst_q_n),
    .inc       (byte_ok),
    .cnt       (cnt),
    .last_byte (last_byte)
  );

  bseq_fsm u_fsm (
    .clk          (clk),
    .rst_q_n      (rst_q_n),
    .serial_sel_n (serial_sel_n),
    .wake_rise    (wake_rise),
    .byte_ok      (byte_ok),
    .last_byte    (last_byte),
    .state        (state)
  );

  assign sram_we_o    = byte_ok;
  assign sram_addr_o  = cnt[ADDR_W-1:0];
  assign sram_wdata_o = rx_data_i;
  assign jump_o       = (state == ST_DONE);
  assign jump_addr_o  = SRAM_BASE;
  assign ext_fetch_o  = (state == ST_NORMAL);

  // R10: the two boot outcomes exclude each other
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(jump_o && ext_fetch_o));
  // R4: no write strobe before the wake rise has moved the machine on
  p_no_write_standby_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STANDBY) |-> !sram_we_o);
  // R9: once the image is complete no strobe appears
  p_no_write_after_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    jump_o |-> !sram_we_o);
  // R8: jump request holds once raised
  p_jump_sticky_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    jump_o |=> jump_o);

endmodule

// File: tb/sim_serial_boot_seq.sv
module sim_serial_boot_seq;

  localparam int CLK_PERIOD = 10;
  localparam int IMG        = 2048;
  localparam logic [31:0] BASE = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap_n_i;
  logic        wake_i;
  logic        rx_valid_i;
  logic [7:0]  rx_data_i;
  logic        rx_err_i;
  logic        sram_we_o;
  logic [10:0] sram_addr_o;
  logic [7:0]  sram_wdata_o;
  logic        jump_o;
  logic [31:0] jump_addr_o;
  logic        ext_fetch_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_boot_seq u0 (
    .clk (clk), .rst_n (rst_n), .strap_n_i (strap_n_i), .wake_i (wake_i),
    .rx_valid_i (rx_valid_i), .rx_data_i (rx_data_i), .rx_err_i (rx_err_i),
    .sram_we_o (sram_we_o), .sram_addr_o (sram_addr_o), .sram_wdata_o (sram_wdata_o),
    .jump_o (jump_o), .jump_addr_o (jump_addr_o), .ext_fetch_o (ext_fetch_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset(input logic strap, input logic wake_lvl);
    @(negedge clk);
    rst_n = 1'b0; strap_n_i = strap; wake_i = wake_lvl;
    rx_valid_i = 1'b0; rx_data_i = 8'h00; rx_err_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!sram_we_o && !jump_o && !ext_fetch_o, "R1", "outputs in reset",
          {sram_we_o, jump_o, ext_fetch_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!sram_we_o && !jump_o && !ext_fetch_o, "R1", "outputs after release",
          {sram_we_o, jump_o, ext_fetch_o}, 0);
  endtask

  // drives one UART byte for one cycle, at a negedge; returns strobe seen
  task automatic offer(input logic [7:0] d, input logic err, output logic we,
                       output logic [10:0] a, output logic [7:0] wd);
    @(negedge clk);
    rx_valid_i = 1'b1; rx_data_i = d; rx_err_i = err;
    #1;
    we = sram_we_o; a = sram_addr_o; wd = sram_wdata_o;
    @(negedge clk);
    rx_valid_i = 1'b0; rx_err_i = 1'b0;
  endtask

  task automatic raise_wake();
    @(negedge clk); wake_i = 1'b0;
    repeat (3) @(negedge clk);
    wake_i = 1'b1;
  endtask

  // External boot, strap flipped after release, latency of the wake rise
  task automatic t_external();
    logic we; logic [10:0] a; logic [7:0] wd;
    do_reset(1'b1, 1'b0);
    strap_n_i = 1'b0;                       // R2: ignored after release
    offer(8'h5A, 1'b0, we, a, wd);
    check(!we, "R4", "strobe in standby", we, 0);
    raise_wake();
    @(posedge clk); @(posedge clk); #1;
    check(!ext_fetch_o, "R3", "release after 2 edges", ext_fetch_o, 0);
    @(posedge clk); #1;
    check(ext_fetch_o, "R3", "release after 3 edges", ext_fetch_o, 1);
    check(ext_fetch_o, "R2", "strap change after release ignored", ext_fetch_o, 1);
    for (int i = 0; i < 4; i++) begin
      offer(8'(i), 1'b0, we, a, wd);
      check(!we, "R5", "strobe in external boot", we, 0);
    end
    check(ext_fetch_o && !jump_o, "R5", "release held, no jump",
          {ext_fetch_o, jump_o}, 2'b10);
    check(!(ext_fetch_o && jump_o), "R10", "exclusive outcomes",
          {ext_fetch_o, jump_o}, 2'b10);
  endtask

  // Wake already high at release must not start the boot
  task automatic t_wake_level();
    do_reset(1'b1, 1'b1);
    repeat (10) @(negedge clk);
    #1;
    check(!ext_fetch_o, "R3", "high level at release not an edge", ext_fetch_o, 0);
    raise_wake();
    repeat (4) @(negedge clk);
    #1;
    check(ext_fetch_o, "R3", "later rise starts boot", ext_fetch_o, 1);
  endtask

  // Serial load with gaps and framing errors, then completion
  task automatic t_serial();
    logic we; logic [10:0] a; logic [7:0] wd;
    int bad_we = 0, bad_addr = 0, bad_data = 0, bad_err = 0;
    do_reset(1'b0, 1'b0);
    strap_n_i = 1'b1;                       // R2: ignored after release
    offer(8'hA5, 1'b0, we, a, wd);
    check(!we, "R4", "strobe before wake", we, 0);
    raise_wake();
    repeat (4) @(negedge clk);
    #1;
    check(!ext_fetch_o, "R2", "serial mode despite late strap change", ext_fetch_o, 0);
    for (int i = 0; i < IMG; i++) begin
      logic [7:0] d;
      d = 8'((i * 7 + 3) & 8'hFF);
      if (i % 5 == 2) begin
        offer(~d, 1'b1, we, a, wd);
        if (we) begin
          bad_err++;
          check(1'b0, "R7", "strobe on framing error", we, 0);
        end
      end
      if (i % 7 == 3) @(negedge clk);
      offer(d, 1'b0, we, a, wd);
      if (!we) begin
        bad_we++;
        check(1'b0, "R6", $sformatf("strobe for byte %0d", i), we, 1);
      end
      if (a != 11'(i)) begin
        bad_addr++;
        check(1'b0, "R7", $sformatf("address for byte %0d", i), a, i);
      end
      if (wd != d) begin
        bad_data++;
        check(1'b0, "R6", $sformatf("data for byte %0d", i), wd, d);
      end
      if (i < IMG - 1 && jump_o) check(1'b0, "R8", "early jump", jump_o, 0);
    end
    check(bad_we == 0, "R6", "all good bytes strobed", bad_we, 0);
    check(bad_data == 0, "R6", "all data passed", bad_data, 0);
    check(bad_addr == 0, "R7", "addresses unshifted by dropped bytes", bad_addr, 0);
    check(bad_err == 0, "R7", "framing errors dropped", bad_err, 0);
    check(jump_o, "R8", "jump after last byte", jump_o, 1);
    check(jump_addr_o == BASE, "R8", "jump target", jump_addr_o, BASE);
    check(!ext_fetch_o, "R10", "no external release with jump", ext_fetch_o, 0);
    for (int k = 0; k < 3; k++) begin
      offer(8'hEE, 1'b0, we, a, wd);
      check(!we, "R9", "strobe after completion", we, 0);
    end
    check(jump_o, "R8", "jump held", jump_o, 1);
  endtask

  initial begin
    rst_n = 1'b0; strap_n_i = 1'b1; wake_i = 1'b0;
    rx_valid_i = 1'b0; rx_data_i = 8'h00; rx_err_i = 1'b0;
    t_external();
    t_wake_level();
    t_serial();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule